// File: doc/BRIEF.md
# Trace Line Cache with Weighted Victim Selection

This block is a small, fully associative store of dynamic instruction traces. Each entry records one trace: the address it starts at, how many branches it spans (0 to 3), the direction each branch went, how many instruction words it holds (up to 16), and the words themselves. A fetch stage presents an address and a vector of predicted branch directions. The block answers in the same cycle with a hit and the stored trace when a valid entry carries that start address and its recorded directions agree with the prediction.

Completed traces arrive from a fill buffer through a one-cycle insert strobe. A trace whose start address is already stored replaces that entry. Otherwise it takes the lowest-numbered free entry. Only when every entry is valid does it displace an existing trace. That victim is the entry with the smallest score, where the score is twice the branch count plus the number of taken branches. Short traces and traces that run almost straight are therefore the first to go. Ties go to the lowest index.

Top module: `trace_line_cache`

## Requirements
- R1: After reset every entry is invalid, and every lookup misses.
- R2: A lookup hits only when a valid entry's start address equals the lookup address. On a hit the block returns that entry's branch count, direction bits, instruction count and 16 words (word k sits in bits [32k+31:32k]) in the same cycle. At most one entry matches.
- R3: Only the low N predicted-direction bits are compared, where N is the stored branch count. Bit i belongs to branch i, and 1 means taken. An entry with zero branches hits on its address alone.
- R4: A difference in any compared direction bit makes the lookup miss.
- R5: An insert is written at the clock edge where the strobe is sampled high. A lookup made in the cycle of the insert still sees the old contents. The new trace is visible from the next cycle on.
- R6: While a free entry exists, an insert fills the lowest-numbered free entry and leaves every stored trace intact.
- R7: An insert whose start address is already stored overwrites that entry. No other entry is lost.
- R8: With all entries valid, an insert of a new address evicts the entry with the smallest score. The score is 2 × branch count + the count of set direction bits among the low (branch count) bits. Direction bits above the branch count do not count.
- R9: When several entries share the smallest score, the lowest index is evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_addr | input | 32 | Lookup start address |
| lk_pred | input | 3 | Predicted directions, bit i for branch i |
| lk_hit | output | 1 | Lookup hit |
| lk_br_cnt | output | 2 | Branch count of the hit trace |
| lk_dirs | output | 3 | Stored directions of the hit trace |
| lk_insn_cnt | output | 5 | Instruction count of the hit trace |
| lk_words | output | 512 | Instruction words of the hit trace |
| ins_valid | input | 1 | Insert strobe |
| ins_addr | input | 32 | Start address of the trace to insert |
| ins_br_cnt | input | 2 | Branch count of the trace to insert |
| ins_dirs | input | 3 | Branch directions of the trace to insert |
| ins_insn_cnt | input | 5 | Instruction count of the trace to insert |
| ins_words | input | 512 | Instruction words of the trace to insert |

## Verification
Corrupt entry state only shows up when a lookup touches it. A wrong valid bit, tag or direction field gives a miss or a false hit on the first lookup of that address after the faulty edge. A wrong score or slot choice is silent until the cache is full. The faulty eviction then shows one insert later: a trace that should survive misses, or the one that should be gone still hits. The directed scenarios therefore fill the cache with chosen scores and probe every address after each eviction.

// File: rtl/tcache_pkg.sv
package tcache_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 16;
    localparam int MAX_BR     = 3;
    localparam int BR_W       = $clog2(MAX_BR + 1);
    localparam int CNT_W      = $clog2(LINE_WORDS + 1);
    localparam int WGT_W      = $clog2(3 * MAX_BR + 1);

    typedef struct packed {
        logic [ADDR_W-1:0]                  start;
        logic [BR_W-1:0]                    br_cnt;
        logic [MAX_BR-1:0]                  dirs;
        logic [CNT_W-1:0]                   insn_cnt;
        logic [LINE_WORDS-1:0][WORD_W-1:0]  words;
    } tline_t;

    // Low n bits set: the direction bits that are meaningful for a line.
    function automatic logic [MAX_BR-1:0] br_mask(input logic [BR_W-1:0] n);
        logic [MAX_BR-1:0] m;
        for (int i = 0; i < MAX_BR; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    // Replacement score: blocks count double, taken branches add one.
    function automatic logic [WGT_W-1:0] line_score(input logic [BR_W-1:0] n,
                                                    input logic [MAX_BR-1:0] d);
        logic [WGT_W-1:0] taken;
        taken = WGT_W'($countones(d & br_mask(n)));
        return WGT_W'({n, 1'b0}) + taken;
    endfunction
endpackage

// File: rtl/tc_match.sv
module tc_match
    import tcache_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0]   valid,
    input  tline_t [ENTRIES-1:0] lines,
    input  logic [ADDR_W-1:0]    look_addr,
    input  logic [MAX_BR-1:0]    look_pred,
    input  logic [ADDR_W-1:0]    put_addr,
    output logic [ENTRIES-1:0]   hit_vec,
    output logic [ENTRIES-1:0]   dup_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic tag_eq;
        logic pred_ok;
        assign tag_eq     = (lines[g].start == look_addr);
        assign pred_ok    = ((look_pred ^ lines[g].dirs) & br_mask(lines[g].br_cnt)) == '0;
        assign hit_vec[g] = valid[g] && tag_eq && pred_ok;
        assign dup_vec[g] = valid[g] && (lines[g].start == put_addr);
    end
endmodule

// File: rtl/tc_victim.sv
module tc_victim
    import tcache_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]   valid,
    input  tline_t [ENTRIES-1:0] lines,
    output logic                 free_any,
    output logic [IDX_W-1:0]     free_idx,
    output logic [IDX_W-1:0]     evict_idx
);
    logic [WGT_W-1:0] score [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_score
        assign score[g] = line_score(lines[g].br_cnt, lines[g].dirs);
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        logic [WGT_W-1:0] best;
        best      = score[0];
        evict_idx = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (score[i] < best) begin
                best      = score[i];
                evict_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/trace_line_cache.sv
module trace_line_cache
    import tcache_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            lk_addr,
    input  logic [MAX_BR-1:0]            lk_pred,
    output logic                         lk_hit,
    output logic [BR_W-1:0]              lk_br_cnt,
    output logic [MAX_BR-1:0]            lk_dirs,
    output logic [CNT_W-1:0]             lk_insn_cnt,
    output logic [LINE_WORDS*WORD_W-1:0] lk_words,
    input  logic                         ins_valid,
    input  logic [ADDR_W-1:0]            ins_addr,
    input  logic [BR_W-1:0]              ins_br_cnt,
    input  logic [MAX_BR-1:0]            ins_dirs,
    input  logic [CNT_W-1:0]             ins_insn_cnt,
    input  logic [LINE_WORDS*WORD_W-1:0] ins_words
);
    typedef struct packed {
        logic [ENTRIES-1:0]   valid;
        tline_t [ENTRIES-1:0] lines;
    } state_t;

    state_t state_d, state_q;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] dup_vec;
    logic               addr_present;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   evict_idx;
    logic [IDX_W-1:0]   dup_idx;
    logic [IDX_W-1:0]   ins_slot;
    tline_t             new_line;
    tline_t             hit_line;

    assign valid_q = state_q.valid;

    tc_match #(.ENTRIES(ENTRIES)) u_match (
        .valid     (state_q.valid),
        .lines     (state_q.lines),
        .look_addr (lk_addr),
        .look_pred (lk_pred),
        .put_addr  (ins_addr),
        .hit_vec   (hit_vec),
        .dup_vec   (dup_vec)
    );

    tc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid     (state_q.valid),
        .lines     (state_q.lines),
        .free_any  (free_any),
        .free_idx  (free_idx),
        .evict_idx (evict_idx)
    );

    // Read side: pick the (single) matching line.
    always_comb begin
        hit_line = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_line = state_q.lines[i];
        end
    end

    assign lk_hit      = |hit_vec;
    assign lk_br_cnt   = hit_line.br_cnt;
    assign lk_dirs     = hit_line.dirs;
    assign lk_insn_cnt = hit_line.insn_cnt;
    assign lk_words    = hit_line.words;

    // Write side: same-address entry first, then a free one, then the victim.
    always_comb begin
        dup_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (dup_vec[i]) dup_idx = IDX_W'(i);
        end
    end

    assign addr_present = |dup_vec;
    assign ins_slot     = addr_present ? dup_idx : (free_any ? free_idx : evict_idx);

    always_comb begin
        new_line.start    = ins_addr;
        new_line.br_cnt   = ins_br_cnt;
        new_line.dirs     = ins_dirs;
        new_line.insn_cnt = ins_insn_cnt;
        new_line.words    = ins_words;
    end

    always_comb begin
        state_d = state_q;
        if (ins_valid) begin
            state_d.valid[ins_slot] = 1'b1;
            state_d.lines[ins_slot] = new_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/trace_line_cache_chk.sv
module trace_line_cache_chk #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_valid,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] hit_vec,
    input logic               addr_present,
    input logic [IDX_W-1:0]   ins_slot
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> valid_q == '0); // R1

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R2

    AST_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> valid_q[$past(ins_slot)]); // R5

    AST_FREE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !addr_present && !(&valid_q))
        |=> $countones(valid_q) == $countones($past(valid_q)) + 1); // R6

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q & $past(valid_q)) == $past(valid_q)); // R6

    AST_OVERWRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && addr_present) |=> valid_q == $past(valid_q)); // R7
endmodule

bind trace_line_cache trace_line_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .valid_q      (valid_q),
    .hit_vec      (hit_vec),
    .addr_present (addr_present),
    .ins_slot     (ins_slot)
);

// File: tb/test_trace_line_cache.sv
module test_trace_line_cache;
    localparam int CLK_PERIOD = 10;
    localparam int WW = 32 * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   lk_addr = '0;
    logic [2:0]    lk_pred = '0;
    logic          lk_hit;
    logic [1:0]    lk_br_cnt;
    logic [2:0]    lk_dirs;
    logic [4:0]    lk_insn_cnt;
    logic [WW-1:0] lk_words;
    logic          ins_valid = 1'b0;
    logic [31:0]   ins_addr = '0;
    logic [1:0]    ins_br_cnt = '0;
    logic [2:0]    ins_dirs = '0;
    logic [4:0]    ins_insn_cnt = '0;
    logic [WW-1:0] ins_words = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trace_line_cache i_trace_line_cache (
        .clk, .rst_n, .lk_addr, .lk_pred, .lk_hit, .lk_br_cnt, .lk_dirs,
        .lk_insn_cnt, .lk_words, .ins_valid, .ins_addr, .ins_br_cnt,
        .ins_dirs, .ins_insn_cnt, .ins_words
    );

    function automatic logic [WW-1:0] mkw(input int seed);
        logic [WW-1:0] w;
        for (int k = 0; k < 16; k++) w[k*32 +: 32] = 32'(seed * 4096 + k);
        return w;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Probe a lookup (combinational) away from the clock edge.
    task automatic probe(input string req, input logic [31:0] a, input logic [2:0] p,
                         input logic exp_hit, input int exp_cnt, input int seed);
        @(negedge clk);
        lk_addr = a;
        lk_pred = p;
        #1;
        chk(req, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) begin
            chk(req, 64'(lk_insn_cnt), 64'(exp_cnt));
            chk(req, 64'(lk_words == mkw(seed)), 64'd1);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [1:0] br, input logic [2:0] d,
                       input int cnt, input int seed);
        @(negedge clk);
        ins_valid    = 1'b1;
        ins_addr     = a;
        ins_br_cnt   = br;
        ins_dirs     = d;
        ins_insn_cnt = 5'(cnt);
        ins_words    = mkw(seed);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        probe("R1 reset miss addr0", 32'h0, 3'b000, 1'b0, 0, 0);
        probe("R1 reset miss addr100", 32'h100, 3'b111, 1'b0, 0, 0);
    endtask

    task automatic t_basic();
        do_reset();
        // Same-cycle lookup must see the old (empty) state: R5.
        @(negedge clk);
        ins_valid = 1'b1; ins_addr = 32'h100; ins_br_cnt = 2'd2; ins_dirs = 3'b010;
        ins_insn_cnt = 5'd7; ins_words = mkw(3);
        lk_addr = 32'h100; lk_pred = 3'b010;
        #1;
        chk("R5 same-cycle miss", 64'(lk_hit), 64'd0);
        @(negedge clk);
        ins_valid = 1'b0;
        probe("R5 visible next cycle", 32'h100, 3'b010, 1'b1, 7, 3);
        chk("R2 branch count out", 64'(lk_br_cnt), 64'd2);
        chk("R2 directions out", 64'(lk_dirs), 64'b010);
        probe("R3 upper bit ignored", 32'h100, 3'b110, 1'b1, 7, 3);
        probe("R4 bit0 differs", 32'h100, 3'b011, 1'b0, 0, 0);
        probe("R4 bit1 differs", 32'h100, 3'b000, 1'b0, 0, 0);
        probe("R2 other address", 32'h104, 3'b010, 1'b0, 0, 0);
        put(32'h200, 2'd0, 3'b101, 4, 5);
        probe("R3 zero branches pred 111", 32'h200, 3'b111, 1'b1, 4, 5);
        probe("R3 zero branches pred 000", 32'h200, 3'b000, 1'b1, 4, 5);
    endtask

    task automatic t_fill_overwrite();
        do_reset();
        for (int i = 0; i < 8; i++) put(32'h400 + 32'(i * 16), 2'd0, 3'b000, i + 1, 10 + i);
        for (int i = 0; i < 8; i++)
            probe("R6 all free slots kept", 32'h400 + 32'(i * 16), 3'b000, 1'b1, i + 1, 10 + i);
        put(32'h430, 2'd1, 3'b001, 9, 77);
        probe("R7 overwritten content", 32'h430, 3'b001, 1'b1, 9, 77);
        for (int i = 0; i < 8; i++)
            if (i != 3)
                probe("R7 others survive", 32'h400 + 32'(i * 16), 3'b000, 1'b1, i + 1, 10 + i);
    endtask

    task automatic t_weight();
        do_reset();
        // scores: all 9, except slot2=3, slot5=2, slot6=2 (bits above count ignored)
        for (int i = 0; i < 8; i++) begin
            if (i == 5)      put(32'h1000 + 32'(i * 64), 2'd1, 3'b000, 2, 20 + i);
            else if (i == 6) put(32'h1000 + 32'(i * 64), 2'd1, 3'b110, 2, 20 + i);
            else if (i == 2) put(32'h1000 + 32'(i * 64), 2'd1, 3'b001, 2, 20 + i);
            else             put(32'h1000 + 32'(i * 64), 2'd3, 3'b111, 16, 20 + i);
        end
        put(32'h9000, 2'd3, 3'b111, 16, 50);
        probe("R8 new line present", 32'h9000, 3'b111, 1'b1, 16, 50);
        probe("R8 lowest score evicted", 32'h1140, 3'b000, 1'b0, 0, 0);
        probe("R8 masked bits not scored", 32'h1180, 3'b110, 1'b1, 2, 26);
        put(32'h9100, 2'd3, 3'b111, 16, 51);
        probe("R8 second victim slot6", 32'h1180, 3'b110, 1'b0, 0, 0);
        probe("R8 taken branch kept slot2", 32'h1080, 3'b001, 1'b1, 2, 22);
        put(32'h9200, 2'd3, 3'b111, 16, 52);
        probe("R8 third victim slot2", 32'h1080, 3'b001, 1'b0, 0, 0);
        for (int i = 0; i < 8; i++)
            if (i != 2 && i != 5 && i != 6)
                probe("R8 high score survive", 32'h1000 + 32'(i * 64), 3'b111, 1'b1, 16, 20 + i);
    endtask

    task automatic t_tie();
        do_reset();
        for (int i = 0; i < 8; i++) put(32'h2000 + 32'(i * 4), 2'd3, 3'b000, 5, 30 + i);
        put(32'h3000, 2'd3, 3'b111, 6, 60);
        probe("R9 tie evicts slot0", 32'h2000, 3'b000, 1'b0, 0, 0);
        probe("R9 slot1 kept", 32'h2004, 3'b000, 1'b1, 5, 31);
        put(32'h3004, 2'd3, 3'b111, 6, 61);
        probe("R9 next tie evicts slot1", 32'h2004, 3'b000, 1'b0, 0, 0);
        probe("R9 slot2 kept", 32'h2008, 3'b000, 1'b1, 5, 32);
        probe("R9 first new kept", 32'h3000, 3'b111, 1'b1, 6, 60);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_basic();
        t_fill_overwrite();
        t_weight();
        t_tie();
        finish_run();
    end
endmodule